// File: doc/BRIEF.md
# Request-Gated Clock Output Enable Controller

This block decides, lane by lane, whether each of eight clock outputs may toggle. Six lanes carry serial-link reference clocks and two carry graphics clocks. For each reference lane, configuration bits supply three controls: a master enable and two select masks. Each mask picks one of two shared, active-low request pins. A selected pin driven high stops the lane, and a low level lets it run. The graphics lanes follow only their own enable bits and are never gated by a request pin.

The wanted state of every lane is formed combinationally. It is carried into the lane's own clock domain through two rising-edge flops, and a two-state machine applies it only on a falling edge of that clock. A downstream AND of the clock with the enable therefore always passes full pulses. Lane order is fixed: lane 0 is reference output 0, lanes 1 to 5 are reference outputs 3 to 7, and lanes 6 and 7 are graphics outputs 0 and 1. If both pins are selected for one lane, the block treats either pin's stop as a stop and raises a status flag.

Each lane machine has two states, STOPPED (reset state) and RUNNING. Transition START (STOPPED to RUNNING) fires at a falling edge when the synchronised wanted state is 1. Transition STOP (RUNNING to STOPPED) fires at a falling edge when it is 0. In every other case the state is held.

Top module: `clkreq_gate_ctrl`

## Requirements
- R1: A graphics lane (6, 7) runs exactly when its bit of `gfx_en` is 1, whatever levels `req_a_n` and `req_b_n` have.
- R2: A reference lane whose `src_master_en` bit is 0 stops, whatever the request pins and select masks are.
- R3: A reference lane with its `src_sel_a` bit set stops while `req_a_n` is 1 and runs (master enable 1, pin B not stopping it) while `req_a_n` is 0.
- R4: A reference lane with its `src_sel_b` bit set stops while `req_b_n` is 1 and runs again when it returns to 0.
- R5: A reference lane with neither select bit set ignores both request pins.
- R6: With both select bits set, the lane stops if either pin is 1, and `dual_select_err` is 1 while any lane has both select bits set (0 otherwise).
- R7: An input change made after a rising edge of a lane clock does not show on `lane_en` until the falling edge that follows the second later rising edge. The old value is still present just after that second rising edge.
- R8: While `rst_n` is 0 every `lane_en` bit is 0, and it stays 0 until the latency of R7 has elapsed after release.
- R9: A `lane_en` bit changes only while its lane clock is low, so it is constant across every high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lane_clk | input | 8 | Per-lane output clock; the enable of lane i is timed by bit i |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_master_en | input | 6 | Master enable per reference lane (lanes 0..5) |
| src_sel_a | input | 6 | Per reference lane: request pin A may stop it |
| src_sel_b | input | 6 | Per reference lane: request pin B may stop it |
| gfx_en | input | 2 | Enable of the graphics lanes 6 and 7 |
| req_a_n | input | 1 | Shared request pin A, active low (1 = stop) |
| req_b_n | input | 1 | Shared request pin B, active low (1 = stop) |
| lane_en | output | 8 | Per-lane enable, changes only while the lane clock is low |
| dual_select_err | output | 1 | Some reference lane has both request pins selected |

## Verification
A lane machine stuck in the wrong state shows at once as a wrong `lane_en` bit. It becomes visible in the low phase after the second rising edge that follows the stimulus. A synchroniser with a missing or extra stage moves that change by one rising edge, so the bench samples just after the second edge (old value expected) and in the following low phase (new value expected). A wrong decode of the masks or pins shows only for the lane and pin combination that exercises it, so the stimulus steps through every pin, mask and override in isolation and then together.

// File: rtl/clkreq_pkg.sv
package clkreq_pkg;
    typedef enum logic {
        LANE_STOPPED = 1'b0,
        LANE_RUNNING = 1'b1
    } lane_state_e;
endpackage

// File: rtl/clkreq_want_decode.sv
module clkreq_want_decode #(
    parameter int NUM_SRC = 6,
    parameter int NUM_GFX = 2,
    localparam int NUM_LANES = NUM_SRC + NUM_GFX
) (
    input  logic [NUM_SRC-1:0]   src_master_en,
    input  logic [NUM_SRC-1:0]   src_sel_a,
    input  logic [NUM_SRC-1:0]   src_sel_b,
    input  logic [NUM_GFX-1:0]   gfx_en,
    input  logic                 req_a_n,
    input  logic                 req_b_n,
    output logic [NUM_LANES-1:0] want_run,
    output logic                 dual_select_err
);
    // Reference lanes: either selected pin driven high stops the lane
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign want_run[i] = src_master_en[i]
                           & ~(src_sel_a[i] & req_a_n)
                           & ~(src_sel_b[i] & req_b_n);
    end

    // Graphics lanes take no request gating
    for (genvar j = 0; j < NUM_GFX; j++) begin : g_gfx
        assign want_run[NUM_SRC+j] = gfx_en[j];
    end

    assign dual_select_err = |(src_sel_a & src_sel_b);
endmodule

// File: rtl/clkreq_lane_gate.sv
module clkreq_lane_gate
    import clkreq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want_run,
    output logic lane_en
);
    logic [SYNC_STAGES-1:0] sync_q;
    lane_state_e            state_q;
    lane_state_e            state_d;

    // Bring the asynchronous wanted state into this lane's clock domain
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], want_run};
        end
    end

    // State register advances on the falling edge only
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LANE_STOPPED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LANE_STOPPED: if (sync_q[SYNC_STAGES-1])  state_d = LANE_RUNNING; // START
            LANE_RUNNING: if (!sync_q[SYNC_STAGES-1]) state_d = LANE_STOPPED; // STOP
            default:      state_d = LANE_STOPPED;
        endcase
    end

    always_comb begin
        lane_en = (state_q == LANE_RUNNING);
    end
endmodule

// File: rtl/clkreq_gate_ctrl.sv
module clkreq_gate_ctrl #(
    parameter int NUM_SRC     = 6,
    parameter int NUM_GFX     = 2,
    parameter int SYNC_STAGES = 2,
    localparam int NUM_LANES  = NUM_SRC + NUM_GFX
) (
    input  logic [NUM_LANES-1:0] lane_clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   src_master_en,
    input  logic [NUM_SRC-1:0]   src_sel_a,
    input  logic [NUM_SRC-1:0]   src_sel_b,
    input  logic [NUM_GFX-1:0]   gfx_en,
    input  logic                 req_a_n,
    input  logic                 req_b_n,
    output logic [NUM_LANES-1:0] lane_en,
    output logic                 dual_select_err
);
    logic [NUM_LANES-1:0] want_run;

    clkreq_want_decode #(
        .NUM_SRC(NUM_SRC),
        .NUM_GFX(NUM_GFX)
    ) u_decode (
        .src_master_en  (src_master_en),
        .src_sel_a      (src_sel_a),
        .src_sel_b      (src_sel_b),
        .gfx_en         (gfx_en),
        .req_a_n        (req_a_n),
        .req_b_n        (req_b_n),
        .want_run       (want_run),
        .dual_select_err(dual_select_err)
    );

    for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
        clkreq_lane_gate #(
            .SYNC_STAGES(SYNC_STAGES)
        ) u_gate (
            .clk     (lane_clk[k]),
            .rst_n   (rst_n),
            .want_run(want_run[k]),
            .lane_en (lane_en[k])
        );
    end
endmodule

// File: rtl/clkreq_gate_ctrl_chk.sv
module clkreq_gate_ctrl_chk #(
    parameter int NUM_SRC    = 6,
    parameter int NUM_GFX    = 2,
    localparam int NUM_LANES = NUM_SRC + NUM_GFX
) (
    input logic [NUM_LANES-1:0] lane_clk,
    input logic                 rst_n,
    input logic [NUM_SRC-1:0]   src_master_en,
    input logic [NUM_SRC-1:0]   src_sel_a,
    input logic [NUM_SRC-1:0]   src_sel_b,
    input logic [NUM_GFX-1:0]   gfx_en,
    input logic                 req_a_n,
    input logic                 req_b_n,
    input logic [NUM_LANES-1:0] lane_en
);
    for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
        logic [1:0] settle_q;
        logic       en_at_rise_q;

        always_ff @(posedge lane_clk[k] or negedge rst_n) begin
            if (!rst_n) begin
                settle_q     <= '0;
                en_at_rise_q <= 1'b0;
            end else begin
                if (settle_q != 2'd3) settle_q <= settle_q + 2'd1;
                en_at_rise_q <= lane_en[k];
            end
        end

        p_high_phase_stable_r9: assert property (
            @(negedge lane_clk[k]) disable iff (!rst_n)
            lane_en[k] == en_at_rise_q
        );

        if (k < NUM_SRC) begin : g_src
            p_master_off_r2: assert property (
                @(posedge lane_clk[k]) disable iff (!rst_n)
                (settle_q >= 2'd2 && !$past(src_master_en[k]) && !$past(src_master_en[k], 2))
                |-> !lane_en[k]
            );
            p_pin_a_stops_r3: assert property (
                @(posedge lane_clk[k]) disable iff (!rst_n)
                (settle_q >= 2'd2 && $past(src_sel_a[k]) && $past(req_a_n)
                 && $past(src_sel_a[k], 2) && $past(req_a_n, 2))
                |-> !lane_en[k]
            );
            p_pin_b_stops_r4: assert property (
                @(posedge lane_clk[k]) disable iff (!rst_n)
                (settle_q >= 2'd2 && $past(src_sel_b[k]) && $past(req_b_n)
                 && $past(src_sel_b[k], 2) && $past(req_b_n, 2))
                |-> !lane_en[k]
            );
        end else begin : g_gfx
            p_gfx_follows_r1: assert property (
                @(posedge lane_clk[k]) disable iff (!rst_n)
                (settle_q >= 2'd2 && $past(gfx_en[k-NUM_SRC]) == $past(gfx_en[k-NUM_SRC], 2))
                |-> lane_en[k] == $past(gfx_en[k-NUM_SRC])
            );
        end
    end

    // R8: held stopped while reset is applied
    always_comb begin
        if (!rst_n) begin
            p_reset_stopped_r8: assert (lane_en == '0);
        end
    end
endmodule

bind clkreq_gate_ctrl clkreq_gate_ctrl_chk #(
    .NUM_SRC(NUM_SRC),
    .NUM_GFX(NUM_GFX)
) u_chk (
    .lane_clk     (lane_clk),
    .rst_n        (rst_n),
    .src_master_en(src_master_en),
    .src_sel_a    (src_sel_a),
    .src_sel_b    (src_sel_b),
    .gfx_en       (gfx_en),
    .req_a_n      (req_a_n),
    .req_b_n      (req_b_n),
    .lane_en      (lane_en)
);

// File: tb/clkreq_gate_ctrl_bench.sv
module clkreq_gate_ctrl_bench;
    localparam int NS = 6;
    localparam int NG = 2;
    localparam int NL = NS + NG;

    typedef struct {
        logic [NL-1:0] en;
        logic          err;
        string         tag;
    } exp_item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] m_en = '1;
    logic [NS-1:0] sa = '0;
    logic [NS-1:0] sb = '0;
    logic [NG-1:0] g_en = '1;
    logic          ra_n = 1'b0;
    logic          rb_n = 1'b0;
    logic [NL-1:0] lane_en;
    logic          dual_err;

    exp_item_t exp_q[$];
    event      sample_ev;
    int        n_checks = 0;
    int        n_fails = 0;
    bit        done = 1'b0;
    logic [NL-1:0] last_en = '0;

    always #4 clk = ~clk;

    clkreq_gate_ctrl #(.NUM_SRC(NS), .NUM_GFX(NG)) u_clkreq_gate_ctrl (
        .lane_clk       ({NL{clk}}),
        .rst_n          (rst_n),
        .src_master_en  (m_en),
        .src_sel_a      (sa),
        .src_sel_b      (sb),
        .gfx_en         (g_en),
        .req_a_n        (ra_n),
        .req_b_n        (rb_n),
        .lane_en        (lane_en),
        .dual_select_err(dual_err)
    );

    function automatic logic [NL-1:0] model_en(
        logic [NS-1:0] m, logic [NS-1:0] a, logic [NS-1:0] b,
        logic [NG-1:0] g, logic pa, logic pb);
        logic [NL-1:0] r;
        for (int i = 0; i < NS; i++) r[i] = m[i] && !(a[i] && pa) && !(b[i] && pb);
        for (int j = 0; j < NG; j++) r[NS+j] = g[j];
        return r;
    endfunction

    // Monitor: pop one expectation per sample point and compare
    initial begin
        forever begin
            @(sample_ev);
            if (exp_q.size() != 0) begin
                exp_item_t it;
                it = exp_q.pop_front();
                n_checks++;
                if (lane_en !== it.en || dual_err !== it.err) begin
                    n_fails++;
                    $display("FAIL %s: lane_en=%b err=%b expected lane_en=%b err=%b",
                             it.tag, lane_en, dual_err, it.en, it.err);
                end
            end
        end
    end

    // Driver: called just after a rising edge; pushes old and new expectations
    task automatic apply(logic [NS-1:0] m, logic [NS-1:0] a, logic [NS-1:0] b,
                         logic [NG-1:0] g, logic pa, logic pb, string tag);
        exp_item_t hold_it;
        exp_item_t new_it;
        m_en = m; sa = a; sb = b; g_en = g; ra_n = pa; rb_n = pb;
        hold_it.en  = last_en;
        hold_it.err = |(a & b);
        hold_it.tag = {tag, " R7 hold after 2nd rise"};
        new_it.en   = model_en(m, a, b, g, pa, pb);
        new_it.err  = |(a & b);
        new_it.tag  = {tag, " R9 low phase after 2nd rise"};
        exp_q.push_back(hold_it);
        exp_q.push_back(new_it);
        @(posedge clk);
        @(posedge clk);
        #1 ->sample_ev;
        #4 ->sample_ev;
        last_en = new_it.en;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R8: stopped under reset
        n_checks++;
        if (lane_en !== '0) begin
            n_fails++;
            $display("FAIL R8 reset: lane_en=%b expected %b", lane_en, {NL{1'b0}});
        end
        @(posedge clk);
        #1 rst_n = 1'b1;
        apply('1, '0, '0, 2'b11, 1'b0, 1'b0, "R8 release all run");
        apply(6'b100101, '0, '0, 2'b11, 1'b1, 1'b1, "R2 R5 master off, pins high");
        apply('1, 6'b000011, '0, 2'b11, 1'b1, 1'b0, "R3 pin A stops lanes 0,1");
        apply('1, 6'b000011, '0, 2'b11, 1'b0, 1'b0, "R3 pin A released");
        apply('1, '0, 6'b111100, 2'b11, 1'b0, 1'b1, "R4 pin B stops lanes 2..5");
        apply('1, '0, 6'b111100, 2'b11, 1'b0, 1'b0, "R4 pin B released");
        apply('1, '0, '0, 2'b11, 1'b1, 1'b1, "R5 no selects, both pins high");
        apply('1, 6'b000001, 6'b000001, 2'b11, 1'b0, 1'b1, "R6 both selected, B stops");
        apply('1, 6'b000001, 6'b000001, 2'b11, 1'b1, 1'b0, "R6 both selected, A stops");
        apply('1, 6'b000001, 6'b000001, 2'b11, 1'b0, 1'b0, "R6 both selected, run");
        apply('1, '1, '0, 2'b01, 1'b1, 1'b1, "R1 gfx1 off, pins high");
        apply('0, '0, '1, 2'b10, 1'b0, 1'b0, "R1 R2 gfx0 off, all masters off");
        apply('1, '0, '0, 2'b11, 1'b0, 1'b0, "R7 back to all run");
        done = 1'b1;
        #20;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule